// File: doc/BRIEF.md
# Multi-Domain Clock Tick Scheduler

This block lets one fast physical clock stand in for several slower logical clock domains, such as a processor pipeline, a memory system and an interconnect. Each domain is given a clock period in picoseconds. The block keeps a global time counter with 1 ps resolution. Each step it runs moves that counter forward by one cycle of the fastest enabled domain, which is the domain with the smallest non-zero period.

Every domain keeps its own next-edge time. On a step, a domain raises a one-cycle tick enable when its next edge is at or before the new global time, and its next edge then moves forward by one period. The ratio between two domains does not have to be an integer. For example, with a 1000 ps domain and a 1499 ps domain, the slower one is skipped on one step in every three. Logic downstream gates its register updates with the tick of its domain. A period of zero disables a domain.

Top module: `tick_sched`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `time_o` to 0 and every tick to 0. It loads each domain's next edge with that domain's period. Periods are to be held steady between resets.
- R2: While `run_i` is low, `time_o` holds its value and all ticks are 0 on the following cycle.
- R3: On each rising edge with `run_i` high and at least one non-zero period, `time_o` grows by exactly the smallest non-zero period.
- R4: The domain with the smallest non-zero period ticks on every step.
- R5: On a step, a domain ticks exactly when its next edge is at or before the new time, and that edge then grows by its period. With periods of 1000 and 1499, the 1499 domain's ticks over steps 1 to 8 are 0,1,1,0,1,1,0,1.
- R6: Domains with equal periods tick on the same steps.
- R7: A domain whose period is 0 never ticks. If every period is 0, `time_o` does not move and no tick is raised.
- R8: Ticks are registered one-cycle pulses. A tick rises on the same edge that `time_o` takes the step's new value.
- R9: Domain i's period sits at `period_i[i*20 +: 20]`, and domain i's tick is `tick_o[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Physical clock shared by every logical domain |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Step enable; one step per clock while high |
| period_i | input | 80 | Four packed 20-bit periods in ps; 0 disables the domain |
| tick_o | output | 4 | Registered per-domain tick enables |
| time_o | output | 48 | Current global time in ps |

## Verification
The bench builds the block with its default parameters: four domains, 20-bit periods and a 48-bit time counter. Four domains are enough for a disabled domain, two domains with a non-integer ratio to the fastest one, and a pair with equal periods that must tick together. Twenty-bit periods hold realistic values such as 1000, 1250, 1499, 2500 and 4000 ps, so the skip-one-in-three pattern and uneven interleavings show up within a few steps. A second configuration makes a domain other than index 0 the fastest, and a configuration with every period at zero exercises the idle case.

// File: rtl/tick_sched_pkg.sv
package tick_sched_pkg;
    localparam int unsigned DEF_NUM_DOM = 4;
    localparam int unsigned DEF_PER_W   = 20;
    localparam int unsigned DEF_TIME_W  = 48;
endpackage

// File: rtl/tick_fastest_sel.sv
// Picks the smallest non-zero period among all domains (R3, R4).
module tick_fastest_sel #(
    parameter int unsigned NUM_DOM = 4,
    parameter int unsigned PER_W   = 20
) (
    input  logic [NUM_DOM*PER_W-1:0] periods_i,
    output logic [PER_W-1:0]         min_per_o,
    output logic                     any_en_o
);
    logic [PER_W-1:0] cand;

    always_comb begin
        min_per_o = '1;
        any_en_o  = 1'b0;
        cand      = '0;
        for (int i = 0; i < NUM_DOM; i++) begin
            cand = periods_i[i*PER_W +: PER_W];
            if (cand != '0 && (!any_en_o || cand < min_per_o)) begin
                min_per_o = cand;
                any_en_o  = 1'b1;
            end
        end
        if (!any_en_o) min_per_o = '0;
    end
endmodule

// File: rtl/tick_dom_edge.sv
// One domain: its next-edge register and registered tick (R5, R7, R8).
module tick_dom_edge #(
    parameter int unsigned PER_W  = 20,
    parameter int unsigned TIME_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [TIME_W-1:0] now_d_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [TIME_W-1:0] nxt;
        logic              tick;
    } dom_st_t;

    dom_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        hit       = step_i && (period_i != '0) && (st_q.nxt <= now_d_i);
        if (hit) begin
            st_d.tick = 1'b1;
            st_d.nxt  = st_q.nxt + TIME_W'(period_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.nxt  <= TIME_W'(period_i);
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/tick_sched.sv
module tick_sched
    import tick_sched_pkg::*;
#(
    parameter int unsigned NUM_DOM = DEF_NUM_DOM,
    parameter int unsigned PER_W   = DEF_PER_W,
    parameter int unsigned TIME_W  = DEF_TIME_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_i,
    input  logic [NUM_DOM*PER_W-1:0] period_i,
    output logic [NUM_DOM-1:0]       tick_o,
    output logic [TIME_W-1:0]        time_o
);
    typedef struct packed {
        logic [TIME_W-1:0] now;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [PER_W-1:0] min_per;
    logic             any_en;
    logic             step;

    tick_fastest_sel #(.NUM_DOM(NUM_DOM), .PER_W(PER_W)) u_sel (
        .periods_i (period_i),
        .min_per_o (min_per),
        .any_en_o  (any_en)
    );

    always_comb begin
        st_d = st_q;
        step = run_i && any_en;
        if (step) st_d.now = st_q.now + TIME_W'(min_per);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.now <= '0;
        else     st_q     <= st_d;
    end

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
        tick_dom_edge #(.PER_W(PER_W), .TIME_W(TIME_W)) u_dom (
            .clk      (clk),
            .rst      (rst),
            .step_i   (step),
            .period_i (period_i[i*PER_W +: PER_W]),
            .now_d_i  (st_d.now),
            .tick_o   (tick_o[i])
        );
    end

    assign time_o = st_q.now;
endmodule

// File: rtl/tick_sched_chk.sv
module tick_sched_chk #(
    parameter int unsigned NUM_DOM = 4,
    parameter int unsigned PER_W   = 20,
    parameter int unsigned TIME_W  = 48
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     run_i,
    input logic [NUM_DOM*PER_W-1:0] period_i,
    input logic [NUM_DOM-1:0]       tick_o,
    input logic [TIME_W-1:0]        time_o
);
    // R2: paused cycles keep time and raise nothing
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> ($stable(time_o) && tick_o == '0));

    // R3: a running step with an enabled domain moves time forward
    assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (run_i && period_i != '0) |=> (time_o > $past(time_o)));

    // R4: some domain (the fastest) ticks on every running step
    assert_fastest_ticks_R4: assert property (@(posedge clk) disable iff (rst)
        (run_i && period_i != '0) |=> (tick_o != '0));

    // R7: all periods zero freezes time
    assert_idle_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (period_i == '0) |=> ($stable(time_o) && tick_o == '0));

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dis
        // R7: a disabled domain stays quiet
        assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
            (period_i[i*PER_W +: PER_W] == '0) |=> !tick_o[i]);
    end
endmodule

bind tick_sched tick_sched_chk #(
    .NUM_DOM (NUM_DOM),
    .PER_W   (PER_W),
    .TIME_W  (TIME_W)
) u_chk (.*);

// File: tb/tick_sched_tb.sv
`timescale 1ns/1ps
module tick_sched_tb;
    localparam int unsigned ND = 4;
    localparam int unsigned PW = 20;
    localparam int unsigned TW = 48;

    logic               clk = 1'b0;
    logic               rst;
    logic               run_i;
    logic [ND*PW-1:0]   period_i;
    logic [ND-1:0]      tick_o;
    logic [TW-1:0]      time_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tick_sched u_dut (
        .clk(clk), .rst(rst), .run_i(run_i),
        .period_i(period_i), .tick_o(tick_o), .time_o(time_o)
    );

    // Config A: d0=1000, d1=1499, d2=1250, d3=0 -> {time, ticks[3:0]}
    localparam logic [TW+ND-1:0] VEC_A [8] = '{
        {48'd1000, 4'b0001},
        {48'd2000, 4'b0111},
        {48'd3000, 4'b0111},
        {48'd4000, 4'b0101},
        {48'd5000, 4'b0111},
        {48'd6000, 4'b0011},
        {48'd7000, 4'b0101},
        {48'd8000, 4'b0111}
    };

    task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [ND*PW-1:0] pack4(input int p0, input int p1, input int p2, input int p3);
        return {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
    endfunction

    task automatic do_reset(input logic [ND*PW-1:0] per);
        @(negedge clk);
        rst = 1'b1; run_i = 1'b0; period_i = per;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 time after reset", time_o, '0);
        chk("R1 ticks after reset", TW'(tick_o), '0);
    endtask

    task automatic step_once();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; run_i = 1'b0; period_i = '0;

        // Config A table walk, with a pause after step 4 (R2)
        do_reset(pack4(1000, 1499, 1250, 0));
        run_i = 1'b1;
        for (int s = 0; s < 8; s++) begin
            step_once();
            chk("R3 time step A", time_o, VEC_A[s][TW+ND-1:ND]);
            chk("R5 ticks A", TW'(tick_o), TW'(VEC_A[s][ND-1:0]));
            chk("R4 fastest d0 ticks", TW'(tick_o[0]), 1);
            chk("R7 disabled d3 quiet", TW'(tick_o[3]), 0);
            if (s == 3) begin
                run_i = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    step_once();
                    chk("R2 paused time", time_o, 48'd4000);
                    chk("R2 paused ticks", TW'(tick_o), 0);
                end
                run_i = 1'b1;
            end
        end
        // R8: one-cycle pulses: pause and confirm ticks drop while time holds
        run_i = 1'b0;
        step_once();
        chk("R8 tick pulse drops", TW'(tick_o), 0);
        chk("R8 time holds", time_o, 48'd8000);

        // Config B: d0 off, d1=d2=2500, d3=4000; fastest is not index 0 (R6)
        do_reset(pack4(0, 2500, 2500, 4000));
        run_i = 1'b1;
        step_once();
        chk("R3 time B1", time_o, 48'd2500);
        chk("R6 ticks B1", TW'(tick_o), TW'(4'b0110));
        step_once();
        chk("R3 time B2", time_o, 48'd5000);
        chk("R6 ticks B2", TW'(tick_o), TW'(4'b1110));
        step_once();
        chk("R9 ticks B3", TW'(tick_o), TW'(4'b0110));
        step_once();
        chk("R3 time B4", time_o, 48'd10000);
        chk("R5 ticks B4", TW'(tick_o), TW'(4'b1110));

        // Config C: everything off (R7)
        do_reset('0);
        run_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step_once();
            chk("R7 idle time", time_o, 0);
            chk("R7 idle ticks", TW'(tick_o), 0);
        end

        // Mid-run reset returns to zero and restarts edges (R1)
        do_reset(pack4(1000, 1499, 0, 0));
        run_i = 1'b1;
        step_once();
        chk("R1 restart time", time_o, 48'd1000);
        chk("R1 restart ticks", TW'(tick_o), TW'(4'b0001));
        step_once();
        chk("R5 restart ticks", TW'(tick_o), TW'(4'b0011));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule